// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Front End

This block gathers the interrupt events of a real-time-clock peripheral and presents them to a host on one level-sensitive request line. Five event sources each deliver a one-cycle pulse. Every pulse latches a sticky status bit. Each status bit is then gated by a per-source mask bit.

The host reaches the block over a small register bus. The bus has a write strobe, a read strobe, an address and a data word that carries only the implemented source bits. The mask is never written as a whole word. Bits are turned on through a set port and turned off through a separate unset port, so two agents can change different bits without a read-modify-write. Status bits are cleared by writing ones to an acknowledge port.

The request line is high whenever a status bit and its mask bit are both set. The line may be shared with other peripherals, so the host reads status and mask to decide whether the request is its own. The mask can be hidden at build time, in which case reads of it return zero.

Top module: `rtc_irq_front`

## Requirements
- R1: Source bit positions are fixed: bit 0 update acknowledge, bit 1 alarm, bit 2 second event, bit 3 time event, bit 4 calendar event. A pulse on `ev_i[k]` sets status bit k at the next clock edge.
- R2: A write to address 2 (mask set) turns on exactly the mask bits that are 1 in the write data. All other mask bits keep their value.
- R3: A write to address 3 (mask unset) turns off exactly the mask bits that are 1 in the write data. All other mask bits keep their value.
- R4: A read strobe returns, on `rdata_o` in the following cycle, the status at address 0 and the mask at address 1. The mask reads as zero when `MASK_READABLE` is 0. Any other address reads zero. `rdata_o` holds its value between reads.
- R5: A write to address 4 (acknowledge) clears the status bits that are 1 in the write data. Zero bits leave status unchanged.
- R6: `irq_o` is high exactly when the bitwise AND of status and mask is nonzero. It follows any register change with no added delay.
- R7: When an event pulse and an acknowledge of the same status bit arrive in the same cycle, the event wins and the bit stays set.
- R8: Synchronous reset (`rst_i` high) clears all status and mask bits and holds `irq_o` low.
- R9: Status bits latch events whether or not they are masked.
- R10: A read issued in the cycle right after a write observes that write's effect.
- R11: Writes to addresses 0 and 1 change neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | SRC_N | Write data, one bit per source |
| ev_i | input | SRC_N | One-cycle event pulses, one per source |
| rdata_o | output | SRC_N | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is an acknowledge that lands in the same clock cycle as a new event on the same source. The race decides whether an event is lost, and it only occurs when the write strobe and the pulse coincide. The bench drives both on a single falling edge, for every source alone and in combination with cleared neighbours. The interrupt line is also swept over all 1024 status and mask pairs, so every gating combination is produced directly.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_STATUS = 3'd0,
    REG_MASK   = 3'd1,
    REG_SET    = 3'd2,
    REG_UNSET  = 3'd3,
    REG_ACK    = 3'd4
  } reg_sel_e;

  localparam int SRC_UPD   = 0;
  localparam int SRC_ALARM = 1;
  localparam int SRC_SEC   = 2;
  localparam int SRC_TIME  = 3;
  localparam int SRC_CAL   = 4;
endpackage

// File: rtl/rtc_irq_mask.sv
module rtc_irq_mask #(
  parameter int SRC_N = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SRC_N-1:0] set_i,
  input  logic [SRC_N-1:0] unset_i,
  output logic [SRC_N-1:0] mask_o
);
  function automatic logic [SRC_N-1:0] mask_next(input logic [SRC_N-1:0] cur,
                                                 input logic [SRC_N-1:0] on,
                                                 input logic [SRC_N-1:0] off);
    return (cur | on) & ~off;
  endfunction

  always_ff @(posedge clk_i) begin
    if (rst_i) mask_o <= '0;
    else       mask_o <= mask_next(mask_o, set_i, unset_i);
  end
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status #(
  parameter int SRC_N = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SRC_N-1:0] ev_i,
  input  logic [SRC_N-1:0] ack_i,
  output logic [SRC_N-1:0] status_o
);
  // Event has priority over acknowledge (R7).
  function automatic logic bit_next(input logic cur, input logic ev, input logic ack);
    return ev | (cur & ~ack);
  endfunction

  for (genvar k = 0; k < SRC_N; k++) begin : g_bit
    always_ff @(posedge clk_i) begin
      if (rst_i) status_o[k] <= 1'b0;
      else       status_o[k] <= bit_next(status_o[k], ev_i[k], ack_i[k]);
    end
  end
endmodule

// File: rtl/rtc_irq_rdmux.sv
module rtc_irq_rdmux
  import rtc_irq_pkg::*;
#(
  parameter int SRC_N         = 5,
  parameter bit MASK_READABLE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [SRC_N-1:0]  status_i,
  input  logic [SRC_N-1:0]  mask_i,
  output logic [SRC_N-1:0]  rdata_o
);
  logic [SRC_N-1:0] mask_view;
  logic [SRC_N-1:0] sel_data;

  if (MASK_READABLE) begin : g_mask_vis
    assign mask_view = mask_i;
  end else begin : g_mask_hid
    assign mask_view = '0;
  end

  always_comb begin
    case (addr_i)
      REG_STATUS: sel_data = status_i;
      REG_MASK:   sel_data = mask_view;
      default:    sel_data = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rdata_o <= '0;
    else if (rd_en_i) rdata_o <= sel_data;
  end
endmodule

// File: rtl/rtc_irq_front.sv
module rtc_irq_front
  import rtc_irq_pkg::*;
#(
  parameter int SRC_N         = 5,
  parameter bit MASK_READABLE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [SRC_N-1:0]  wdata_i,
  input  logic [SRC_N-1:0]  ev_i,
  output logic [SRC_N-1:0]  rdata_o,
  output logic              irq_o
);
  // Named internal events, visible to the bound checker.
  logic [SRC_N-1:0] set_req;
  logic [SRC_N-1:0] unset_req;
  logic [SRC_N-1:0] ack_req;
  logic [SRC_N-1:0] status_q;
  logic [SRC_N-1:0] mask_q;
  logic [SRC_N-1:0] pending;

  assign set_req   = (wr_en_i && addr_i == REG_SET)   ? wdata_i : '0;
  assign unset_req = (wr_en_i && addr_i == REG_UNSET) ? wdata_i : '0;
  assign ack_req   = (wr_en_i && addr_i == REG_ACK)   ? wdata_i : '0;

  rtc_irq_mask #(.SRC_N(SRC_N)) mask_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .set_i   (set_req),
    .unset_i (unset_req),
    .mask_o  (mask_q)
  );

  rtc_irq_status #(.SRC_N(SRC_N)) status_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .ev_i     (ev_i),
    .ack_i    (ack_req),
    .status_o (status_q)
  );

  rtc_irq_rdmux #(.SRC_N(SRC_N), .MASK_READABLE(MASK_READABLE)) rdmux_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .status_i (status_q),
    .mask_i   (mask_q),
    .rdata_o  (rdata_o)
  );

  assign pending = status_q & mask_q;
  assign irq_o   = |pending;
endmodule

// File: rtl/rtc_irq_front_chk.sv
module rtc_irq_front_chk
  import rtc_irq_pkg::*;
#(
  parameter int SRC_N         = 5,
  parameter bit MASK_READABLE = 1'b1
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [REG_AW-1:0] addr_i,
  input logic [SRC_N-1:0]  wdata_i,
  input logic [SRC_N-1:0]  ev_i,
  input logic [SRC_N-1:0]  rdata_o,
  input logic              irq_o,
  input logic [SRC_N-1:0]  status_q,
  input logic [SRC_N-1:0]  mask_q
);
  assert_mask_set_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && addr_i == REG_SET) |=> (mask_q == ($past(mask_q) | $past(wdata_i))));

  assert_mask_unset_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && addr_i == REG_UNSET) |=> (mask_q == ($past(mask_q) & ~$past(wdata_i))));

  // Mask moves only on set/unset writes (R2, R3, R11).
  assert_mask_hold_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    !(wr_en_i && (addr_i == REG_SET || addr_i == REG_UNSET)) |=> $stable(mask_q));

  assert_mask_read_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_en_i && addr_i == REG_MASK) |=>
      (rdata_o == (MASK_READABLE ? $past(mask_q) : '0)));

  assert_status_read_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_en_i && addr_i == REG_STATUS) |=> (rdata_o == $past(status_q)));

  assert_rdata_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_en_i |=> $stable(rdata_o));

  assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && addr_i == REG_ACK && ev_i == '0) |=>
      (status_q == ($past(status_q) & ~$past(wdata_i))));

  assert_event_wins_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (ev_i != '0) |=> ((status_q & $past(ev_i)) == $past(ev_i)));

  assert_no_irq_unmasked_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (mask_q == '0) |-> !irq_o);

  assert_irq_needs_status_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_q == '0) |-> !irq_o);

  assert_reset_clears_R8: assert property (@(posedge clk_i)
    rst_i |=> (status_q == '0 && mask_q == '0 && !irq_o));
endmodule

bind rtc_irq_front rtc_irq_front_chk #(
  .SRC_N(SRC_N), .MASK_READABLE(MASK_READABLE)
) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .ev_i(ev_i), .rdata_o(rdata_o),
  .irq_o(irq_o), .status_q(status_q), .mask_q(mask_q)
);

// File: tb/rtc_irq_front_tb.sv
module rtc_irq_front_tb_top;
  localparam int N = 5;
  localparam logic [2:0] A_STATUS = 3'd0;
  localparam logic [2:0] A_MASK   = 3'd1;
  localparam logic [2:0] A_SET    = 3'd2;
  localparam logic [2:0] A_UNSET  = 3'd3;
  localparam logic [2:0] A_ACK    = 3'd4;
  localparam logic [N-1:0] ALL = 5'h1F;

  logic clk = 1'b0;
  logic rst;
  logic wr_en, rd_en;
  logic [2:0] addr;
  logic [N-1:0] wdata, ev, rdata;
  logic irq;
  int errs = 0;
  int chks = 0;

  always #5 clk = ~clk;

  rtc_irq_front dut_i (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .ev_i(ev), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    chks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [N-1:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = '0;
  endtask

  task automatic pulse_ack(input logic [N-1:0] e, input logic [N-1:0] c);
    @(negedge clk); ev = e; wr_en = 1'b1; addr = A_ACK; wdata = c;
    @(negedge clk); ev = '0; wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errs++; chks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin : main
    logic [N-1:0] d;
    logic [N-1:0] m_model;
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; ev = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8: reset state
    check("R8 irq after reset", int'(irq), 0);
    bus_rd(A_STATUS, d); check("R8 status after reset", int'(d), 0);
    bus_rd(A_MASK, d);   check("R8 mask after reset", int'(d), 0);

    // R2, R10: set sweep from empty mask, read immediately after write
    for (int v = 0; v < 32; v++) begin
      bus_wr(A_UNSET, ALL);
      bus_wr(A_SET, N'(v));
      bus_rd(A_MASK, d); check("R2 R10 set sweep", int'(d), v);
    end
    // R2: incremental set keeps other bits
    bus_wr(A_UNSET, ALL);
    m_model = '0;
    for (int k = 0; k < N; k++) begin
      bus_wr(A_SET, N'(1 << k));
      m_model = m_model | N'(1 << k);
      bus_rd(A_MASK, d); check("R2 incremental set", int'(d), int'(m_model));
    end
    // R3: unset sweep from full mask
    for (int v = 0; v < 32; v++) begin
      bus_wr(A_SET, ALL);
      bus_wr(A_UNSET, N'(v));
      bus_rd(A_MASK, d); check("R3 R10 unset sweep", int'(d), int'(~N'(v) & ALL));
    end

    // R1: source bit positions
    bus_wr(A_UNSET, ALL);
    for (int k = 0; k < N; k++) begin
      bus_wr(A_ACK, ALL);
      pulse(N'(1 << k));
      bus_rd(A_STATUS, d); check("R1 source bit", int'(d), 1 << k);
    end

    // R6, R9: every status x mask pair
    for (int s = 0; s < 32; s++) begin
      for (int m = 0; m < 32; m++) begin
        bus_wr(A_UNSET, ALL);
        bus_wr(A_SET, N'(m));
        bus_wr(A_ACK, ALL);
        pulse(N'(s));
        check("R6 irq gating", int'(irq), ((s & m) != 0) ? 1 : 0);
        bus_rd(A_STATUS, d); check("R9 status latched regardless of mask", int'(d), s);
      end
    end

    // R6: irq drops immediately after unset removes the only pending bit
    bus_wr(A_ACK, ALL); bus_wr(A_SET, ALL); pulse(5'h04);
    check("R6 irq raised", int'(irq), 1);
    bus_wr(A_UNSET, 5'h04);
    check("R6 irq dropped by unset", int'(irq), 0);

    // R5: write-one-to-clear, zeros ignored
    for (int v = 0; v < 32; v++) begin
      pulse(ALL);
      bus_wr(A_ACK, N'(v));
      bus_rd(A_STATUS, d); check("R5 ack clears ones", int'(d), int'(~N'(v) & ALL));
    end
    pulse(5'h15);
    bus_wr(A_ACK, 5'h00);
    bus_rd(A_STATUS, d); check("R5 ack zero no effect", int'(d), 'h15);

    // R7: event and ack on the same bit in the same cycle
    for (int k = 0; k < N; k++) begin
      pulse(ALL);
      pulse_ack(N'(1 << k), ALL);
      bus_rd(A_STATUS, d); check("R7 event wins over ack", int'(d), 1 << k);
    end
    pulse(5'h0A);
    pulse_ack(5'h11, 5'h1B);
    bus_rd(A_STATUS, d); check("R7 mixed event and ack", int'(d), 'h11);

    // R11: writes to read-only addresses have no effect
    bus_wr(A_ACK, ALL); bus_wr(A_UNSET, ALL);
    bus_wr(A_STATUS, ALL);
    bus_wr(A_MASK, ALL);
    bus_rd(A_STATUS, d); check("R11 status unchanged", int'(d), 0);
    bus_rd(A_MASK, d);   check("R11 mask unchanged", int'(d), 0);
    check("R11 irq low", int'(irq), 0);

    // R4: unmapped address reads zero, rdata holds between reads
    pulse(5'h13);
    bus_rd(3'd6, d); check("R4 unmapped reads zero", int'(d), 0);
    bus_rd(A_STATUS, d);
    repeat (3) @(negedge clk);
    check("R4 rdata holds", int'(rdata), 'h13);

    // R8: reset in mid-run
    bus_wr(A_SET, ALL); pulse(ALL);
    check("R8 irq before reset", int'(irq), 1);
    do_reset();
    check("R8 irq after mid reset", int'(irq), 0);
    bus_rd(A_STATUS, d); check("R8 status after mid reset", int'(d), 0);
    bus_rd(A_MASK, d);   check("R8 mask after mid reset", int'(d), 0);

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule